// File: doc/BRIEF.md
# SPI Real-Time-Clock Register Interface

This block is the serial front end of a small real-time-clock register file. An SPI master opens a transaction by raising chip select and sending one address byte; the top bit of that byte chooses a write burst or a read burst, and the low seven bits give the starting register. Every data byte that follows goes to, or comes from, the next register in turn, because the address steps forward after each complete byte.

The block runs on a fast system clock and oversamples the serial pins through synchronizer stages. It keeps the control byte, the trickle-charge byte and a general-purpose RAM region itself. Timekeeping, alarm and status registers belong to neighbouring logic, and the block reaches them through one-cycle read and write strobes with an address and a data byte. A write-protect bit in the control byte gates every write except a write to the control byte itself. The protect state in force is the one the control byte held when the address byte of the transaction completed.

Top module: `rtcspi_regif`

## Requirements
- R1: The first byte after chip select rises is the address byte. Bit 7 = 1 selects a write transaction and bit 7 = 0 a read transaction. Bits 6:0 give the start address.
- R2: Chip select is active high. With CPOL = 0 the serial clock idles low. The master changes MOSI on the leading (rising) edge and the block samples it on the trailing (falling) edge. The block updates MISO after each leading edge. Bytes travel most significant bit first.
- R3: Within one transaction the address increases by one after every complete data byte, and it wraps from 0x7F to 0x00.
- R4: Addresses 0x00 to 0x0E and 0x10 are forwarded to the neighbouring logic. A write gives a one-cycle ext_wr with ext_addr and ext_wdata. A read gives one ext_rd per data byte, issued at the first leading edge of that byte. The block takes ext_rdata in the clock after ext_rd.
- R5: The control byte at 0x0F is held in the block and resets to 0x40. Bits 5:3 always read as zero, and bit 6 is write protect. Its value is visible on ctrl_q.
- R6: A read of the status byte at 0x10 returns zero in bits 7:2, whatever ext_rdata carries. Bits 1:0 come from ext_rdata.
- R7: The trickle byte at 0x11 is held in the block as a full 8-bit register that resets to 0x00. Its value is visible on trickle_q.
- R8: Addresses 0x20 to 0x7F are general-purpose RAM that reads back what was last written.
- R9: Addresses 0x12 to 0x1F read as 0x00. Writes to them have no effect.
- R10: Write protect is sampled when the address byte completes. While that sampled value is 1, writes to every address except 0x0F are dropped: no ext_wr is issued and no internal byte changes. A change of write protect applies from the next transaction on.
- R11: If chip select falls in the middle of a byte, that partial byte is discarded and nothing is written. The bit counter clears, and the next transaction starts again with an address byte.
- R12: spi_miso_oe is high only while chip select is asserted. spi_miso is 0 whenever spi_miso_oe is low.
- R13: ext_wr and ext_rd are single-cycle pulses and are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, many times faster than the serial clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spi_sclk | input | 1 | Serial clock from the master |
| spi_cs | input | 1 | Chip select, active high |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| spi_miso_oe | output | 1 | Output enable for spi_miso |
| ext_wr | output | 1 | Write strobe to timekeeping, alarm and status logic |
| ext_rd | output | 1 | Read strobe to timekeeping, alarm and status logic |
| ext_addr | output | 7 | Register address that goes with either strobe |
| ext_wdata | output | 8 | Write data that goes with ext_wr |
| ext_rdata | input | 8 | Read data, valid in the clock after ext_rd |
| ctrl_q | output | 8 | Current control byte |
| trickle_q | output | 8 | Current trickle byte |

## Verification
The bench targets the write-protect boundary. A burst that starts at the control byte and clears protect must still have its later status and trickle bytes dropped; a design that applied the new protect value at once would let those bytes through. It also aborts transactions partway through the address byte and partway through a data byte. A design that kept the partial bits, or failed to return to the address phase, would corrupt the trickle byte or decode the next transaction wrongly. Further cases cover the RAM burst that wraps from 0x7F into the forwarded region, status reads against an all-ones source, and a burst read across the control byte. In that last case a wrong design would either miss the reserved-bit masks or issue read strobes for internal registers.

// File: rtl/rtcspi_pkg.sv
package rtcspi_pkg;

   localparam int unsigned ADDR_W = 7;
   localparam int unsigned DATA_W = 8;

   localparam logic [ADDR_W-1:0] CTRL_ADDR    = 7'h0F;
   localparam logic [ADDR_W-1:0] STAT_ADDR    = 7'h10;
   localparam logic [ADDR_W-1:0] TRICKLE_ADDR = 7'h11;
   localparam logic [ADDR_W-1:0] EXT_LAST     = 7'h10;

   localparam logic [DATA_W-1:0] CTRL_KEEP = 8'hC7;
   localparam logic [DATA_W-1:0] STAT_KEEP = 8'h03;
   localparam int unsigned       WP_BIT    = 6;

   typedef enum logic [2:0] {
      RG_EXT,
      RG_CTRL,
      RG_TRICKLE,
      RG_RAM,
      RG_NONE
   } region_e;

   function automatic region_e decode_addr(input logic [ADDR_W-1:0] a,
                                           input int unsigned ram_base,
                                           input int unsigned ram_bytes);
      region_e r;
      if (a == CTRL_ADDR)
         r = RG_CTRL;
      else if (a <= EXT_LAST)
         r = RG_EXT;
      else if (a == TRICKLE_ADDR)
         r = RG_TRICKLE;
      else if (32'(a) >= ram_base && 32'(a) < ram_base + ram_bytes)
         r = RG_RAM;
      else
         r = RG_NONE;
      return r;
   endfunction

endpackage

// File: rtl/rtcspi_sync.sv
module rtcspi_sync #(
   parameter int unsigned STAGES  = 2,
   parameter bit          RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else if (STAGES == 1) begin : g_one
         logic flop;
         always_ff @(posedge clk) begin
            if (!rst_n) flop <= RST_VAL;
            else        flop <= d;
         end
         assign q = flop;
      end else begin : g_chain
         logic [STAGES-1:0] pipe;
         always_ff @(posedge clk) begin
            if (!rst_n) pipe <= {STAGES{RST_VAL}};
            else        pipe <= {pipe[STAGES-2:0], d};
         end
         assign q = pipe[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/rtcspi_shift.sv
module rtcspi_shift #(
   parameter int unsigned DW   = 8,
   parameter bit          CPOL = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs,
   input  logic          sclk,
   input  logic          mosi,
   input  logic          load,
   input  logic [DW-1:0] load_data,
   output logic          byte_done,
   output logic [DW-1:0] rx_byte,
   output logic          first_lead,
   output logic          miso,
   output logic          miso_oe
);

   localparam int unsigned CW = $clog2(DW);
   localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);

   logic          sclk_p, sclk_d;
   logic          lead, trail;
   logic [CW-1:0] bit_cnt;
   logic [DW-1:0] rx_sr, tx_sr;
   logic          done_q;

   assign sclk_p = sclk ^ CPOL;
   assign lead   = cs &  sclk_p & ~sclk_d;
   assign trail  = cs & ~sclk_p &  sclk_d;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sclk_d  <= 1'b0;
         bit_cnt <= '0;
         rx_sr   <= '0;
         tx_sr   <= '0;
         done_q  <= 1'b0;
      end else begin
         sclk_d <= sclk_p;
         done_q <= 1'b0;
         if (!cs) begin
            bit_cnt <= '0;
            tx_sr   <= '0;
         end else begin
            if (trail) begin
               rx_sr   <= {rx_sr[DW-2:0], mosi};
               bit_cnt <= bit_cnt + CW'(1);
               done_q  <= (bit_cnt == LAST_BIT);
            end
            if (load)
               tx_sr <= load_data;
            else if (lead && bit_cnt != '0)
               tx_sr <= {tx_sr[DW-2:0], 1'b0};
         end
      end
   end

   assign byte_done  = done_q;
   assign rx_byte    = rx_sr;
   assign first_lead = lead & (bit_cnt == '0);
   assign miso       = tx_sr[DW-1] & cs;
   assign miso_oe    = cs;

   // R11
   cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cs |=> (bit_cnt == '0));

endmodule

// File: rtl/rtcspi_txn.sv
module rtcspi_txn
   import rtcspi_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs,
   input  logic              byte_done,
   input  logic [DATA_W-1:0] rx_byte,
   input  logic              first_lead,
   input  logic              wp_now,
   output logic              wr_en,
   output logic              rd_fetch,
   output logic              load,
   output logic [ADDR_W-1:0] addr
);

   logic in_data, is_wr, wp_txn, load_q;
   logic wr_allow;

   assign wr_allow = !wp_txn || (addr == CTRL_ADDR);
   assign wr_en    = byte_done & in_data & is_wr & wr_allow;
   assign rd_fetch = first_lead & in_data & ~is_wr;
   assign load     = load_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_data <= 1'b0;
         is_wr   <= 1'b0;
         wp_txn  <= 1'b0;
         addr    <= '0;
         load_q  <= 1'b0;
      end else begin
         load_q <= rd_fetch;
         if (byte_done) begin
            if (!in_data) begin
               in_data <= 1'b1;
               is_wr   <= rx_byte[DATA_W-1];
               addr    <= rx_byte[ADDR_W-1:0];
               wp_txn  <= wp_now;
            end else begin
               addr <= addr + ADDR_W'(1);
            end
         end else if (!cs) begin
            in_data <= 1'b0;
         end
      end
   end

   // R3
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && in_data) |=> (addr == $past(addr) + ADDR_W'(1)));

   // R10
   wp_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_data) |-> (wp_txn == $past(wp_now)));

endmodule

// File: rtl/rtcspi_regs.sv
module rtcspi_regs
   import rtcspi_pkg::*;
#(
   parameter int unsigned       RAM_BASE      = 32,
   parameter int unsigned       RAM_BYTES     = 96,
   parameter logic [DATA_W-1:0] CTRL_RESET    = 8'h40,
   parameter logic [DATA_W-1:0] TRICKLE_RESET = 8'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [DATA_W-1:0] ext_rdata,
   output region_e           region,
   output logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0] ctrl_q,
   output logic [DATA_W-1:0] trickle_q
);

   localparam int unsigned RIW = (RAM_BYTES > 1) ? $clog2(RAM_BYTES) : 1;

   logic [DATA_W-1:0] ram_rd;

   assign region = decode_addr(addr, RAM_BASE, RAM_BYTES);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q    <= CTRL_RESET & CTRL_KEEP;
         trickle_q <= TRICKLE_RESET;
      end else if (wr_en) begin
         if (region == RG_CTRL)    ctrl_q    <= wr_data & CTRL_KEEP;
         if (region == RG_TRICKLE) trickle_q <= wr_data;
      end
   end

   generate
      if (RAM_BYTES == 0) begin : g_no_ram
         assign ram_rd = '0;
      end else begin : g_ram
         logic [DATA_W-1:0] mem [RAM_BYTES];
         logic [ADDR_W-1:0] ram_off;
         assign ram_off = addr - ADDR_W'(RAM_BASE);
         always_ff @(posedge clk) begin
            if (wr_en && region == RG_RAM)
               mem[ram_off[RIW-1:0]] <= wr_data;
         end
         assign ram_rd = mem[ram_off[RIW-1:0]];
      end
   endgenerate

   always_comb begin
      unique case (region)
         RG_CTRL:    rd_data = ctrl_q;
         RG_TRICKLE: rd_data = trickle_q;
         RG_RAM:     rd_data = ram_rd;
         RG_EXT:     rd_data = (addr == STAT_ADDR) ? (ext_rdata & STAT_KEEP) : ext_rdata;
         default:    rd_data = '0;
      endcase
   end

   // R5
   ctrl_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q[5:3] == 3'b000);

endmodule

// File: rtl/rtcspi_regif.sv
module rtcspi_regif
   import rtcspi_pkg::*;
#(
   parameter int unsigned       RAM_BASE      = 32,
   parameter int unsigned       RAM_BYTES     = 96,
   parameter int unsigned       SYNC_STAGES   = 2,
   parameter bit                CPOL          = 1'b0,
   parameter logic [DATA_W-1:0] CTRL_RESET    = 8'h40,
   parameter logic [DATA_W-1:0] TRICKLE_RESET = 8'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_sclk,
   input  logic              spi_cs,
   input  logic              spi_mosi,
   output logic              spi_miso,
   output logic              spi_miso_oe,
   output logic              ext_wr,
   output logic              ext_rd,
   output logic [ADDR_W-1:0] ext_addr,
   output logic [DATA_W-1:0] ext_wdata,
   input  logic [DATA_W-1:0] ext_rdata,
   output logic [DATA_W-1:0] ctrl_q,
   output logic [DATA_W-1:0] trickle_q
);

   localparam int unsigned MAP_TOP = 1 << ADDR_W;

   generate
      if (RAM_BASE <= 32'(TRICKLE_ADDR) || RAM_BASE + RAM_BYTES > MAP_TOP) begin : g_bad_map
         $error("RAM window overlaps fixed registers or leaves the address space");
      end
      if ((CTRL_RESET & ~CTRL_KEEP) != '0) begin : g_bad_ctrl
         $error("control reset value sets reserved bits");
      end
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("synchronizer depth above four is not supported");
      end
   endgenerate

   logic cs_s, sclk_s, mosi_s;
   logic byte_done, first_lead, load, wr_en, rd_fetch;
   logic [DATA_W-1:0] rx_byte, rd_data;
   logic [ADDR_W-1:0] addr;
   region_e           region;

   rtcspi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_cs (
      .clk(clk), .rst_n(rst_n), .d(spi_cs), .q(cs_s));
   rtcspi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(CPOL)) u_sync_sclk (
      .clk(clk), .rst_n(rst_n), .d(spi_sclk), .q(sclk_s));
   rtcspi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_mosi (
      .clk(clk), .rst_n(rst_n), .d(spi_mosi), .q(mosi_s));

   rtcspi_shift #(.DW(DATA_W), .CPOL(CPOL)) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs         (cs_s),
      .sclk       (sclk_s),
      .mosi       (mosi_s),
      .load       (load),
      .load_data  (rd_data),
      .byte_done  (byte_done),
      .rx_byte    (rx_byte),
      .first_lead (first_lead),
      .miso       (spi_miso),
      .miso_oe    (spi_miso_oe)
   );

   rtcspi_txn u_txn (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs         (cs_s),
      .byte_done  (byte_done),
      .rx_byte    (rx_byte),
      .first_lead (first_lead),
      .wp_now     (ctrl_q[WP_BIT]),
      .wr_en      (wr_en),
      .rd_fetch   (rd_fetch),
      .load       (load),
      .addr       (addr)
   );

   rtcspi_regs #(
      .RAM_BASE      (RAM_BASE),
      .RAM_BYTES     (RAM_BYTES),
      .CTRL_RESET    (CTRL_RESET),
      .TRICKLE_RESET (TRICKLE_RESET)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .addr      (addr),
      .wr_data   (rx_byte),
      .ext_rdata (ext_rdata),
      .region    (region),
      .rd_data   (rd_data),
      .ctrl_q    (ctrl_q),
      .trickle_q (trickle_q)
   );

   assign ext_wr    = wr_en    & (region == RG_EXT);
   assign ext_rd    = rd_fetch & (region == RG_EXT);
   assign ext_addr  = addr;
   assign ext_wdata = rx_byte;

   // R13
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ext_wr && ext_rd));

   // R13
   rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ext_rd |=> !ext_rd);

   // R4
   ext_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_wr || ext_rd) |-> (ext_addr <= EXT_LAST && ext_addr != CTRL_ADDR));

   // R12
   miso_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !spi_miso_oe |-> !spi_miso);

endmodule

// File: tb/sim_rtcspi_regif.sv
module sim_rtcspi_regif;

   localparam int HALF = 13;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic       rst_n, sclk, cs, mosi;
   logic       miso, miso_oe, ext_wr, ext_rd;
   logic [6:0] ext_addr;
   logic [7:0] ext_wdata, ext_rdata, ctrl_q, trickle_q;

   rtcspi_regif u0 (
      .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs(cs), .spi_mosi(mosi),
      .spi_miso(miso), .spi_miso_oe(miso_oe), .ext_wr(ext_wr), .ext_rd(ext_rd),
      .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata),
      .ctrl_q(ctrl_q), .trickle_q(trickle_q));

   // neighbouring timekeeping / status storage with one-cycle read latency
   logic [7:0] periph [0:31];
   always @(posedge clk) begin
      if (ext_wr) periph[ext_addr[4:0]] <= ext_wdata;
      if (ext_rd) ext_rdata <= periph[ext_addr[4:0]];
   end

   int vec = 0;
   int bad = 0;
   int rd_seen = 0;
   logic prev_rd = 1'b0;

   logic [7:0]  m_ext [0:31];
   logic [7:0]  m_ram [0:127];
   logic [7:0]  m_ctrl = 8'h40;
   logic [7:0]  m_trk  = 8'h00;
   logic [14:0] exp_q[$];
   logic [7:0]  txb[$];
   logic [7:0]  rxb[$];
   logic [7:0]  dq[$];

   function automatic void chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vec++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endfunction

   // per-clock monitor of the register-side strobes
   always @(negedge clk) begin
      if (rst_n) begin
         if (ext_wr) begin
            vec++;
            if (exp_q.size() == 0) begin
               bad++;
               $display("FAIL R10 unexpected write actual=%0h expected=none", {ext_addr, ext_wdata});
            end else begin
               logic [14:0] e;
               e = exp_q.pop_front();
               if ({ext_addr, ext_wdata} !== e) begin
                  bad++;
                  $display("FAIL R4 write actual=%0h expected=%0h", {ext_addr, ext_wdata}, e);
               end
            end
         end
         if (ext_wr && ext_rd) begin
            bad++;
            $display("FAIL R13 strobes actual=11 expected=not both");
         end
         if (ext_rd && prev_rd) begin
            bad++;
            $display("FAIL R13 read pulse actual=2 cycles expected=1");
         end
         if (ext_rd) rd_seen++;
         prev_rd = ext_rd;
      end
   end

   function automatic logic [7:0] exp_rd(input logic [6:0] a);
      if (a == 7'h0F)      return m_ctrl;
      else if (a == 7'h10) return m_ext[16] & 8'h03;
      else if (a < 7'h10)  return m_ext[a[4:0]];
      else if (a == 7'h11) return m_trk;
      else if (a < 7'h20)  return 8'h00;
      else                 return m_ram[a];
   endfunction

   task automatic spi_txn(input int tail_bits);
      logic [7:0] r;
      rxb.delete();
      @(negedge clk);
      cs = 1'b1;
      repeat (HALF) @(negedge clk);
      chk("R12 oe active", {31'd0, miso_oe}, 1);
      for (int i = 0; i < txb.size(); i++) begin
         int nb;
         nb = (i == txb.size() - 1) ? tail_bits : 8;
         r = 8'h00;
         for (int b = 7; b > 7 - nb; b--) begin
            sclk = 1'b1;
            mosi = txb[i][b];
            repeat (HALF) @(negedge clk);
            r[b] = miso;
            sclk = 1'b0;
            repeat (HALF) @(negedge clk);
         end
         rxb.push_back(r);
      end
      repeat (HALF) @(negedge clk);
      cs = 1'b0;
      mosi = 1'b0;
      repeat (3 * HALF) @(negedge clk);
      chk("R12 oe idle", {30'd0, miso_oe, miso}, 0);
   endtask

   task automatic do_write(input logic [6:0] a0);
      logic [6:0] a;
      logic wp;
      wp = m_ctrl[6];
      a = a0;
      txb.delete();
      txb.push_back({1'b1, a0});
      foreach (dq[i]) begin
         txb.push_back(dq[i]);
         if (!wp || a == 7'h0F) begin
            if (a == 7'h0F) m_ctrl = dq[i] & 8'hC7;
            else if (a <= 7'h10) begin
               m_ext[a[4:0]] = dq[i];
               exp_q.push_back({a, dq[i]});
            end
            else if (a == 7'h11) m_trk = dq[i];
            else if (a >= 7'h20) m_ram[a] = dq[i];
         end
         a = a + 7'd1;
      end
      spi_txn(8);
      chk("R4 pending writes", exp_q.size(), 0);
      dq.delete();
   endtask

   task automatic do_read(input logic [6:0] a0, input int n, input string req);
      logic [6:0] a;
      int nexp;
      txb.delete();
      txb.push_back({1'b0, a0});
      for (int i = 0; i < n; i++) txb.push_back(8'h00);
      rd_seen = 0;
      spi_txn(8);
      a = a0;
      nexp = 0;
      for (int i = 0; i < n; i++) begin
         chk(req, rxb[i+1], exp_rd(a));
         if (a <= 7'h10 && a != 7'h0F) nexp++;
         a = a + 7'd1;
      end
      chk("R4 read strobe count", rd_seen, nexp);
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      vec++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; sclk = 1'b0; cs = 1'b0; mosi = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // reset state: R5 R7 R12
      chk("R5 ctrl reset", ctrl_q, 8'h40);
      chk("R7 trickle reset", trickle_q, 8'h00);
      chk("R12 oe reset", miso_oe, 0);
      chk("R12 miso reset", miso, 0);

      // R1 R2 read of internal bytes after reset
      do_read(7'h0F, 1, "R2 ctrl read");
      do_read(7'h11, 1, "R7 trickle read");

      // R10 protected writes are dropped
      dq = '{8'h55};
      do_write(7'h11);
      chk("R10 trickle kept", trickle_q, 8'h00);
      dq = '{8'h12};
      do_write(7'h03);

      // R10 clearing protect in a burst leaves the rest of that burst protected
      dq = '{8'h00, 8'hFF, 8'hA5};
      do_write(7'h0F);
      chk("R10 ctrl cleared", ctrl_q, 8'h00);
      chk("R10 same-burst trickle blocked", trickle_q, 8'h00);

      // R5 reserved control bits
      dq = '{8'h3F};
      do_write(7'h0F);
      chk("R5 ctrl masked", ctrl_q, 8'h07);
      dq = '{8'h00};
      do_write(7'h0F);

      // R6 status masking
      dq = '{8'hFF};
      do_write(7'h10);
      do_read(7'h10, 1, "R6 status read");

      // R3 R4 burst writes to the forwarded region, burst read across it
      dq = '{8'h59, 8'h34, 8'h12, 8'h03, 8'h28, 8'h02, 8'h24};
      do_write(7'h00);
      dq = '{8'h01, 8'h02, 8'h03, 8'h80, 8'h11, 8'h22, 8'h33, 8'h44};
      do_write(7'h07);
      do_read(7'h00, 18, "R3 burst read");

      // R7 trickle
      dq = '{8'hA9};
      do_write(7'h11);
      chk("R7 trickle written", trickle_q, 8'hA9);

      // R8 RAM
      dq = '{8'hDE, 8'hAD, 8'hBE, 8'hEF};
      do_write(7'h20);
      do_read(7'h20, 4, "R8 ram read");

      // R3 wrap from 0x7F into address 0x00
      dq = '{8'h11, 8'h22, 8'h33};
      do_write(7'h7E);
      do_read(7'h7E, 3, "R3 wrap read");

      // R9 unimplemented addresses
      dq = '{8'h77};
      do_write(7'h15);
      do_read(7'h12, 2, "R9 hole read");
      do_read(7'h1F, 2, "R9 hole edge read");

      // R11 abort inside a data byte
      txb.delete();
      txb.push_back(8'h91);
      txb.push_back(8'h5A);
      spi_txn(5);
      chk("R11 partial byte dropped", trickle_q, 8'hA9);
      do_read(7'h11, 1, "R11 next txn read");

      // R11 abort inside the address byte
      txb.delete();
      txb.push_back(8'h8F);
      spi_txn(4);
      chk("R11 partial address ctrl", ctrl_q, 8'h00);
      do_read(7'h20, 2, "R11 after address abort");

      // R10 protect set again blocks RAM writes
      dq = '{8'h40};
      do_write(7'h0F);
      chk("R10 ctrl protect", ctrl_q, 8'h40);
      dq = '{8'hEE};
      do_write(7'h21);
      do_read(7'h20, 4, "R10 ram unchanged");
      dq = '{8'h5C};
      do_write(7'h05);
      do_read(7'h05, 1, "R10 time unchanged");

      finish_run();
   end

endmodule